// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Unit

This block decides, every clock, which warps of one streaming multiprocessor send an instruction to the execution hardware. It has two schedulers. Scheduler 0 owns the even-numbered warp contexts and scheduler 1 owns the odd-numbered ones. There are four execution columns: two core columns, each 16 lanes wide, a load/store column and a narrow special-function column. Each scheduler can issue at most one instruction per cycle, so at most two warps issue in a cycle and they go to distinct columns. The block tracks how long each column stays occupied by a 32-thread warp. It also enforces the pairing rules: a double-precision operation takes both core columns at once, and the special-function column stays busy for several cycles while issue to the other columns continues.

Each warp context presents a descriptor made of a valid bit and a 2-bit class tag. The issue strobe works as the handshake. A warp holds `warp_valid` high with a stable class until its ID appears on an asserted column strobe, which means the descriptor was accepted in that cycle. No other back-pressure signal exists. The issue outputs are combinational from the current descriptors and the registered column and warp state, and nothing downstream can stall them. After a warp issues, it is in flight until its `warp_done` pulse arrives. `warp_done` is only pulsed for a warp that is in flight.

Top module: `warp_dual_issue`

## Requirements
- R1: No column strobe is asserted while no warp presents a valid descriptor, including right after reset, and a warp whose `warp_valid` is low never issues.
- R2: Even warps issue only through scheduler 0 and odd warps only through scheduler 1. At most one warp of each parity issues per cycle, so two ALU warps of different parity issue in the same cycle.
- R3: Class codes and strobe bits:
  - Class 2'b00 (ALU) takes core column 0 (strobe bit 0) if it is free, otherwise core column 1 (bit 1).
  - Class 2'b01 (DP) takes both core columns.
  - Class 2'b10 (MEM) takes the load/store column (bit 2).
  - Class 2'b11 (SFU) takes the special-function column (bit 3).
  - `col_warp` field c carries the warp ID for column c.
- R4: When scheduler 0 issues a DP instruction, scheduler 1 issues nothing in that cycle.
- R5: A DP instruction of scheduler 1 is eligible only in a cycle in which scheduler 0 issues nothing.
- R6: A core column that accepts an instruction stays busy for CORE_CYC cycles (default 2), counting the issue cycle.
- R7: The load/store column stays busy for MEM_CYC cycles (default 2) after an issue.
- R8: The special-function column stays busy for SFU_CYC cycles (default 8). Other columns keep accepting instructions during that time.
- R9: Each scheduler picks among its eligible warps in round-robin order, starting from the warp after the one it last issued. After reset, the search starts at its lowest warp.
- R10: Scheduler 0 claims columns first. Scheduler 1 then considers only warps whose target column is still free, so it may issue a different warp in the same cycle.
- R11: A warp that has issued does not issue again until its `warp_done` pulse. It becomes eligible in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NW | Per-warp descriptor valid |
| warp_class | input | 2*NW | Per-warp class tag, warp w in bits [2w+1:2w] |
| warp_done | input | NW | Per-warp completion pulse for the in-flight instruction |
| col_issue | output | 4 | Issue strobe per column: core0, core1, load/store, special-function |
| col_warp | output | 4*$clog2(NW) | Warp ID issued on each column, field c for column c |

## Verification
Each pattern below targets one rule and is built so that a faulty implementation would produce a different result.

- Two ALU warps of opposite parity arriving together must split across the two core columns. This separates true dual issue from a single shared issue slot.
- A DP paired with a memory warp, first with the DP on scheduler 0 and then on scheduler 1, tells apart the two deferral rules.
- Competing memory requests, with a spare ALU warp on scheduler 1, show that scheduler 0 wins the column and that scheduler 1 falls back to another warp rather than stalling.
- Back-to-back requests to each column measure its occupancy window.
- A wrap-around sequence in which the lowest-numbered eligible warp is not the next one in rotation separates round-robin from fixed priority.
- A warp that stays valid until its completion pulse shows that it does not issue twice.

// File: rtl/wdi_pkg.sv
package wdi_pkg;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_DP  = 2'd1,
    CLS_MEM = 2'd2,
    CLS_SFU = 2'd3
  } wdi_class_e;

  localparam int NUM_COLS = 4;

  // Column bit order: 0 core0, 1 core1, 2 load/store, 3 special-function
  function automatic logic can_issue(input wdi_class_e c, input logic [3:0] fr,
                                     input logic dp_ok);
    case (c)
      CLS_ALU: can_issue = fr[0] | fr[1];
      CLS_DP:  can_issue = fr[0] & fr[1] & dp_ok;
      CLS_MEM: can_issue = fr[2];
      default: can_issue = fr[3];
    endcase
  endfunction

  function automatic logic [3:0] claim(input wdi_class_e c, input logic [3:0] fr);
    case (c)
      CLS_ALU: claim = fr[0] ? 4'b0001 : 4'b0010;
      CLS_DP:  claim = 4'b0011;
      CLS_MEM: claim = 4'b0100;
      default: claim = 4'b1000;
    endcase
  endfunction

endpackage

// File: rtl/wdi_col_timer.sv
module wdi_col_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic free
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) + 1 : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYC - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign free = (cnt == '0);
endmodule

// File: rtl/wdi_rr_pick.sv
module wdi_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = int'(last) + off;
      if (cand >= N) cand = cand - N;
      if (!gnt_valid && elig[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         last <= IW'(N - 1);
    else if (gnt_valid) last <= gnt_idx;
  end
endmodule

// File: rtl/warp_dual_issue.sv
module warp_dual_issue
  import wdi_pkg::*;
#(
  parameter int NW       = 8,
  parameter int CORE_CYC = 2,
  parameter int MEM_CYC  = 2,
  parameter int SFU_CYC  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NW-1:0]             warp_valid,
  input  logic [2*NW-1:0]           warp_class,
  input  logic [NW-1:0]             warp_done,
  output logic [3:0]                col_issue,
  output logic [4*$clog2(NW)-1:0]   col_warp
);
  // NW must be a power of two, at least 4
  localparam int WID  = $clog2(NW);
  localparam int HALF = NW / 2;
  localparam int LIW  = $clog2(HALF);

  wdi_class_e      cls [NW];
  logic [NW-1:0]   in_flight, rdy, iss_mask;
  logic [3:0]      col_free, free1, take0, take1;
  logic [HALF-1:0] elig0, elig1;
  logic            g0v, g1v, blk1;
  logic [LIW-1:0]  g0i, g1i;
  wdi_class_e      c0, c1;
  logic [WID-1:0]  id0, id1;

  always_comb
    for (int w = 0; w < NW; w++) cls[w] = wdi_class_e'(warp_class[2*w +: 2]);

  assign rdy = warp_valid & ~in_flight;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int CYC = (c < 2) ? CORE_CYC : ((c == 2) ? MEM_CYC : SFU_CYC);
    wdi_col_timer #(.CYC(CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(col_issue[c]), .free(col_free[c]));
  end

  // Scheduler 0: even warps, claims columns first
  always_comb
    for (int k = 0; k < HALF; k++)
      elig0[k] = rdy[2*k] && can_issue(cls[2*k], col_free, 1'b1);

  wdi_rr_pick #(.N(HALF)) u_rr0 (
    .clk(clk), .rst_n(rst_n), .elig(elig0), .gnt_valid(g0v), .gnt_idx(g0i));

  always_comb begin
    c0 = CLS_ALU;
    for (int k = 0; k < HALF; k++) if (LIW'(k) == g0i) c0 = cls[2*k];
  end

  assign take0 = g0v ? claim(c0, col_free) : 4'b0000;
  assign free1 = col_free & ~take0;
  assign blk1  = g0v && (c0 == CLS_DP);

  // Scheduler 1: odd warps, sees only the columns left over
  always_comb
    for (int k = 0; k < HALF; k++)
      elig1[k] = rdy[2*k+1] && !blk1 && can_issue(cls[2*k+1], free1, !g0v);

  wdi_rr_pick #(.N(HALF)) u_rr1 (
    .clk(clk), .rst_n(rst_n), .elig(elig1), .gnt_valid(g1v), .gnt_idx(g1i));

  always_comb begin
    c1 = CLS_ALU;
    for (int k = 0; k < HALF; k++) if (LIW'(k) == g1i) c1 = cls[2*k+1];
  end

  assign take1 = g1v ? claim(c1, free1) : 4'b0000;

  assign id0 = {g0i, 1'b0};
  assign id1 = {g1i, 1'b1};
  assign col_issue = take0 | take1;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_out
    assign col_warp[c*WID +: WID] = take0[c] ? id0 : (take1[c] ? id1 : '0);
  end

  always_comb begin
    iss_mask = '0;
    if (g0v) iss_mask[id0] = 1'b1;
    if (g1v) iss_mask[id1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_flight <= '0;
    else        in_flight <= (in_flight | iss_mask) & ~warp_done;
  end
endmodule

// File: rtl/wdi_checker.sv
module wdi_checker #(
  parameter int NW       = 8,
  parameter int CORE_CYC = 2,
  parameter int MEM_CYC  = 2,
  parameter int SFU_CYC  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NW-1:0]           warp_valid,
  input logic [NW-1:0]           warp_done,
  input logic [3:0]              col_issue,
  input logic [4*$clog2(NW)-1:0] col_warp
);
  localparam int WID = $clog2(NW);

  logic [NW-1:0] issued, busy_w, even_m;
  int unsigned   gap [4];

  always_comb begin
    issued = '0;
    for (int c = 0; c < 4; c++)
      if (col_issue[c]) issued[col_warp[c*WID +: WID]] = 1'b1;
    for (int w = 0; w < NW; w++) even_m[w] = (w % 2 == 0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_w <= '0;
      for (int c = 0; c < 4; c++) gap[c] <= 0;
    end else begin
      busy_w <= (busy_w | issued) & ~warp_done;
      for (int c = 0; c < 4; c++) begin
        if (col_issue[c])
          gap[c] <= (c < 2) ? CORE_CYC - 1 : ((c == 2) ? MEM_CYC - 1 : SFU_CYC - 1);
        else if (gap[c] != 0)
          gap[c] <= gap[c] - 1;
      end
    end
  end

  AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (issued & ~warp_valid) == '0); // R1
  AST_ONE_PER_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(issued & even_m) <= 1) && ($countones(issued & ~even_m) <= 1)); // R2
  AST_DP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_issue[0] && col_issue[1] && (col_warp[0 +: WID] == col_warp[WID +: WID]))
    |-> (col_issue[3:2] == 2'b00)); // R4
  AST_CORE0_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[0] |-> (gap[0] == 0)); // R6
  AST_CORE1_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[1] |-> (gap[1] == 0)); // R6
  AST_MEM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[2] |-> (gap[2] == 0)); // R7
  AST_SFU_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue[3] |-> (gap[3] == 0)); // R8
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (issued & busy_w) == '0); // R11
endmodule

bind warp_dual_issue wdi_checker #(
  .NW(NW), .CORE_CYC(CORE_CYC), .MEM_CYC(MEM_CYC), .SFU_CYC(SFU_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_done(warp_done),
  .col_issue(col_issue), .col_warp(col_warp)
);

// File: tb/warp_dual_issue_tb_top.sv
module warp_dual_issue_tb_top;
  localparam int NW = 8;
  localparam logic [1:0] K_ALU = 2'd0, K_DP = 2'd1, K_MEM = 2'd2, K_SFU = 2'd3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW-1:0]   warp_valid = '0;
  logic [2*NW-1:0] warp_class = '0;
  logic [NW-1:0]   warp_done = '0;
  logic [3:0]      col_issue;
  logic [11:0]     col_warp;

  int errors = 0;
  int checks = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  warp_dual_issue #(.NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_class(warp_class),
    .warp_done(warp_done), .col_issue(col_issue), .col_warp(col_warp));

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic set_w(input int w, input bit v, input logic [1:0] c);
    warp_valid[w] = v;
    warp_class[2*w +: 2] = c;
  endtask

  // ei: expected strobes; e0..e3: expected warp per column (checked where strobe set)
  task automatic chk(input string tag, input logic [3:0] ei,
                     input logic [2:0] e0, input logic [2:0] e1,
                     input logic [2:0] e2, input logic [2:0] e3);
    logic [11:0] ew;
    bit ok;
    #1;
    ew = {e3, e2, e1, e0};
    ok = (col_issue == ei);
    for (int c = 0; c < 4; c++)
      if (ei[c] && col_warp[c*3 +: 3] != ew[c*3 +: 3]) ok = 0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: issue=%b warps=%h expected issue=%b warps=%h",
               tag, col_issue, col_warp, ei, ew);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    warp_valid = '0;
    warp_done = '0;
    repeat (3) nxt();
    rst_n = 1'b1;
  endtask

  task automatic idle_all();
    warp_valid = '0;
    warp_done = '1;
    nxt();
    warp_done = '0;
    repeat (9) nxt();
  endtask

  task automatic t_reset();  // R1
    rst_n = 1'b0;
    nxt();
    chk("R1 in reset", 4'b0000, 0, 0, 0, 0);
    rst_n = 1'b1;
    set_w(5, 0, K_SFU);
    set_w(2, 0, K_ALU);
    nxt();
    chk("R1 idle after reset", 4'b0000, 0, 0, 0, 0);
    nxt();
    chk("R1 invalid warps ignored", 4'b0000, 0, 0, 0, 0);
    idle_all();
  endtask

  task automatic t_dual_alu();  // R2 R3
    set_w(0, 1, K_ALU);
    set_w(1, 1, K_ALU);
    chk("R2 dual ALU issue", 4'b0011, 0, 1, 0, 0);
    nxt();
    chk("R11 no reissue while in flight", 4'b0000, 0, 0, 0, 0);
    idle_all();
  endtask

  task automatic t_core_gap();  // R6
    set_w(2, 1, K_ALU);
    set_w(3, 1, K_ALU);
    chk("R3 ALU to both cores", 4'b0011, 2, 3, 0, 0);
    nxt();
    set_w(2, 0, K_ALU);
    set_w(3, 0, K_ALU);
    set_w(4, 1, K_ALU);
    set_w(5, 1, K_ALU);
    chk("R6 cores busy", 4'b0000, 0, 0, 0, 0);
    nxt();
    chk("R6 cores free again", 4'b0011, 4, 5, 0, 0);
    idle_all();
  endtask

  task automatic t_dp_s0();  // R4
    set_w(0, 1, K_DP);
    set_w(1, 1, K_MEM);
    chk("R4 DP on sched0 alone", 4'b0011, 0, 0, 0, 0);
    nxt();
    set_w(0, 0, K_DP);
    chk("R4 deferred mem issues", 4'b0100, 0, 0, 1, 0);
    idle_all();
  endtask

  task automatic t_dp_s1();  // R5
    set_w(0, 1, K_MEM);
    set_w(1, 1, K_DP);
    chk("R5 sched1 DP deferred", 4'b0100, 0, 0, 0, 0);
    nxt();
    set_w(0, 0, K_MEM);
    chk("R5 sched1 DP issues alone", 4'b0011, 1, 1, 0, 0);
    idle_all();
  endtask

  task automatic t_mem_conflict();  // R7 R10
    set_w(0, 1, K_MEM);
    set_w(1, 1, K_MEM);
    set_w(3, 1, K_ALU);
    chk("R10 sched0 wins, sched1 falls back", 4'b0101, 3, 0, 0, 0);
    nxt();
    set_w(0, 0, K_MEM);
    set_w(3, 0, K_ALU);
    chk("R7 load/store busy", 4'b0000, 0, 0, 0, 0);
    nxt();
    chk("R7 load/store free", 4'b0100, 0, 0, 1, 0);
    idle_all();
  endtask

  task automatic t_sfu();  // R8
    set_w(2, 1, K_SFU);
    chk("R8 SFU issue", 4'b1000, 0, 0, 0, 2);
    nxt();
    set_w(2, 0, K_SFU);
    set_w(3, 1, K_SFU);
    set_w(0, 1, K_MEM);
    chk("R8 mem issues while SFU busy", 4'b0100, 0, 0, 0, 0);
    nxt();
    set_w(0, 0, K_MEM);
    for (int i = 2; i < 8; i++) begin
      chk("R8 SFU still busy", 4'b0000, 0, 0, 0, 0);
      nxt();
    end
    chk("R8 SFU free after 8", 4'b1000, 0, 0, 0, 3);
    idle_all();
  endtask

  task automatic t_inflight();  // R11
    set_w(4, 1, K_ALU);
    chk("R11 first issue", 4'b0001, 4, 0, 0, 0);
    nxt();
    chk("R11 held in flight", 4'b0000, 0, 0, 0, 0);
    nxt();
    warp_done[4] = 1'b1;
    chk("R11 held until done", 4'b0000, 0, 0, 0, 0);
    nxt();
    warp_done[4] = 1'b0;
    chk("R11 reissue after done", 4'b0001, 4, 0, 0, 0);
    idle_all();
  endtask

  task automatic t_rr();  // R9
    do_reset();
    set_w(0, 1, K_ALU);
    set_w(2, 1, K_ALU);
    set_w(4, 1, K_ALU);
    chk("R9 start at lowest", 4'b0001, 0, 0, 0, 0);
    nxt();
    set_w(0, 0, K_ALU);
    chk("R9 next in turn", 4'b0010, 0, 2, 0, 0);
    nxt();
    set_w(2, 0, K_ALU);
    warp_done[0] = 1'b1;
    warp_done[2] = 1'b1;
    chk("R9 third in turn", 4'b0001, 4, 0, 0, 0);
    nxt();
    warp_done = '0;
    set_w(4, 0, K_ALU);
    set_w(2, 1, K_ALU);
    set_w(6, 1, K_ALU);
    chk("R9 rotation beats low index", 4'b0010, 0, 6, 0, 0);
    idle_all();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: expected run to end, still running");
    report();
  end

  initial begin
    do_reset();
    t_reset();
    t_dual_alu();
    t_core_gap();
    t_dp_s0();
    t_dp_s1();
    t_mem_conflict();
    t_sfu();
    t_inflight();
    t_rr();
    report();
  end
endmodule